// File: doc/BRIEF.md
# Per-Bit Nonvolatile Word Store

This block is a behavioural model of the small nonvolatile word that holds a tuning device's capacitor selection. A host loads an 11-bit word one bit at a time, least significant bit first, with a data line and a serial clock. It then either fires a programming strobe or leaves the lines in a read state. The strobe is the digital stand-in for the high-voltage pulse. A word with exactly one zero names a single cell. A strobe applied to that word clears the named cell. A word of all ones with a valid strobe returns every cell to one, which is the shipped state.

The strobe only counts when its high time and the quiet time after it both meet minimums. Both are measured in system-clock cycles. A rejected cycle leaves the store untouched and produces an error pulse. The strobe pin also carries readback. After a full word has been clocked in with one zero, and while data and clock are both held high, the block drives the addressed cell's value. It reports the pin as undriven at all other times.

All three host lines pass through a synchronizer before use. The stored word is always visible on a parallel output, because it is the word that selects the capacitors.

Top module: `nvs_word_store`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every cell reads 1, the readback enable is low and the error pulse is low.
- R2: Each rising edge of the serial clock shifts the data line into the word. The first bit shifted lands in bit 0, and after W edges the bit shifted last sits in bit W-1.
- R3: When a full word has a 0 at exactly one position k, a strobe of at least MIN_PULSE cycles followed by more than MIN_IDLE low cycles clears cell k. No other cell changes and no error is raised.
- R4: A strobe shorter than MIN_PULSE cycles changes no cell and raises one error pulse.
- R5: A strobe that rises again before the quiet time has elapsed aborts the cycle. The abort changes no cell and raises an error pulse.
- R6: A full all-ones word with a valid strobe and quiet time sets every cell to 1, including the check cell at bit 0.
- R7: A valid strobe on a word with two or more zeros changes no cell and raises an error pulse.
- R8: A valid strobe with fewer than W clock edges since the last programming cycle changes no cell and raises an error pulse.
- R9: The readback enable goes high when all of these hold: a full word with a single zero at k, data high, clock high, strobe low, and no programming cycle in progress. The readback value then equals cell k, where 0 means cleared and 1 means set.
- R10: Outside that window the readback enable is low and the readback value is 0.
- R11: An error is a single-cycle pulse, and an accepted programming cycle raises none.
- R12: Every programming cycle, accepted or rejected, restarts the bit count. A new full word of W edges is then needed before another program or a readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| da_in | input | 1 | Serial data line |
| sclk_in | input | 1 | Serial clock line, sampled by clk |
| pv_in | input | 1 | Programming strobe (high = pulse) |
| pv_oe | output | 1 | Readback drive enable (0 = pin not driven) |
| pv_rd | output | 1 | Readback value of the addressed cell |
| cell_q | output | W | Stored word |
| err_o | output | 1 | One-cycle pulse for a rejected cycle |

## Verification
The store is driven with single-zero words at low, middle and high positions. Bit 9 in particular separates correct shift order from reversed order, because a reversed shift would hit bit 1. The same single-zero words are applied with a long strobe, a short strobe, and a strobe broken by an early re-rise, which separates the width check from the quiet-time check. Words with two zeros, partial words, and repeated strobes without a reshift show that only a fresh one-zero word is acted on. All-ones words show that erase restores every cell, bit 0 included. Readback is probed on cleared cells, set cells and cells just erased. It is also probed with data low, with a multi-zero word and directly after a commit, to show the window opens only when all of its conditions hold.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_GAP  = 2'd2
  } pulse_ph_e;

  localparam int unsigned HOST_LINES = 3;
  localparam int unsigned LN_DA   = 0;
  localparam int unsigned LN_SCLK = 1;
  localparam int unsigned LN_PV   = 2;
endpackage

// File: rtl/nvs_sync.sv
module nvs_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned N      = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [N-1:0] stage_r [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < int'(STAGES); i++) stage_r[i] <= '0;
        end else begin
          stage_r[0] <= d;
          for (int i = 1; i < int'(STAGES); i++) stage_r[i] <= stage_r[i-1];
        end
      end
      assign q = stage_r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/nvs_shift.sv
module nvs_shift #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         da,
  input  logic         sclk,
  input  logic         clr,
  output logic [W-1:0] word,
  output logic         full
);
  localparam int unsigned CW = $clog2(W + 1);

  logic          sclk_q;
  logic [CW-1:0] cnt;
  logic          rise;

  assign rise = sclk & ~sclk_q;
  assign full = (cnt == CW'(W));

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      word   <= '1;
      cnt    <= '0;
    end else begin
      sclk_q <= sclk;
      if (clr) begin
        cnt <= '0;
      end else if (rise) begin
        word <= {da, word[W-1:1]};
        if (!full) cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/nvs_pulse.sv
module nvs_pulse
  import nvs_pkg::*;
#(
  parameter int unsigned MIN_PULSE = 2000000,
  parameter int unsigned MIN_IDLE  = 800
) (
  input  logic clk,
  input  logic rst,
  input  logic pv,
  output logic busy,
  output logic fire,
  output logic fire_ok,
  output logic abort
);
  localparam int unsigned PW = $clog2(MIN_PULSE + 1);
  localparam int unsigned IW = $clog2(MIN_IDLE + 1);

  pulse_ph_e     ph;
  logic [PW-1:0] wcnt;
  logic [IW-1:0] gcnt;
  logic          ok_r;

  assign busy    = (ph != PH_IDLE);
  assign fire_ok = ok_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_IDLE;
      wcnt  <= '0;
      gcnt  <= '0;
      ok_r  <= 1'b0;
      fire  <= 1'b0;
      abort <= 1'b0;
    end else begin
      fire  <= 1'b0;
      abort <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (pv) begin
            ph   <= PH_HIGH;
            wcnt <= PW'(1);
          end
        end
        PH_HIGH: begin
          if (pv) begin
            if (wcnt != PW'(MIN_PULSE)) wcnt <= wcnt + PW'(1);
          end else begin
            ph   <= PH_GAP;
            gcnt <= IW'(1);
            ok_r <= (wcnt == PW'(MIN_PULSE));
          end
        end
        PH_GAP: begin
          if (pv) begin
            ph    <= PH_IDLE;
            abort <= 1'b1;
          end else if (gcnt == IW'(MIN_IDLE)) begin
            ph   <= PH_IDLE;
            fire <= 1'b1;
          end else begin
            gcnt <= gcnt + IW'(1);
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nvs_cells.sv
module nvs_cells #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] word,
  input  logic         full,
  input  logic         fire,
  input  logic         fire_ok,
  input  logic         abort,
  input  logic         busy,
  input  logic         da,
  input  logic         sclk,
  input  logic         pv,
  output logic [W-1:0] cell_q,
  output logic         rd_oe,
  output logic         rd_val,
  output logic         err
);
  localparam int unsigned CW  = $clog2(W + 1);
  localparam int unsigned IXW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]   inv;
  logic [CW-1:0]  zc;
  logic [IXW-1:0] idx;
  logic           single;
  logic           all_ones;
  logic           window;

  assign inv      = ~word;
  assign all_ones = (word == {W{1'b1}});
  assign single   = (zc == CW'(1));
  assign window   = full & single & da & sclk & ~pv & ~busy & ~fire & ~abort;

  always_comb begin
    zc  = '0;
    idx = '0;
    for (int i = 0; i < int'(W); i++) begin
      if (inv[i]) begin
        zc  = zc + CW'(1);
        idx = IXW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cell_q <= '1;
      err    <= 1'b0;
      rd_oe  <= 1'b0;
      rd_val <= 1'b0;
    end else begin
      err <= 1'b0;
      if (abort) begin
        err <= 1'b1;
      end else if (fire) begin
        if (!fire_ok || !full) err <= 1'b1;
        else if (all_ones)     cell_q <= '1;
        else if (single)       cell_q[idx] <= 1'b0;
        else                   err <= 1'b1;
      end
      rd_oe  <= window;
      rd_val <= window & cell_q[idx];
    end
  end
endmodule

// File: rtl/nvs_word_store.sv
module nvs_word_store
  import nvs_pkg::*;
#(
  parameter int unsigned W           = 11,
  parameter int unsigned MIN_PULSE   = 2000000,
  parameter int unsigned MIN_IDLE    = 800,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         da_in,
  input  logic         sclk_in,
  input  logic         pv_in,
  output logic         pv_oe,
  output logic         pv_rd,
  output logic [W-1:0] cell_q,
  output logic         err_o
);
  logic [HOST_LINES-1:0] raw_l, syn_l;
  logic [W-1:0]          word;
  logic                  full, busy, fire, fire_ok, abort;

  assign raw_l[LN_DA]   = da_in;
  assign raw_l[LN_SCLK] = sclk_in;
  assign raw_l[LN_PV]   = pv_in;

  nvs_sync #(.STAGES(SYNC_STAGES), .N(HOST_LINES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_l), .q(syn_l)
  );

  nvs_shift #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .da(syn_l[LN_DA]), .sclk(syn_l[LN_SCLK]),
    .clr(fire | abort), .word(word), .full(full)
  );

  nvs_pulse #(.MIN_PULSE(MIN_PULSE), .MIN_IDLE(MIN_IDLE)) u_pulse (
    .clk(clk), .rst(rst), .pv(syn_l[LN_PV]), .busy(busy),
    .fire(fire), .fire_ok(fire_ok), .abort(abort)
  );

  nvs_cells #(.W(W)) u_cells (
    .clk(clk), .rst(rst), .word(word), .full(full), .fire(fire),
    .fire_ok(fire_ok), .abort(abort), .busy(busy), .da(syn_l[LN_DA]),
    .sclk(syn_l[LN_SCLK]), .pv(syn_l[LN_PV]), .cell_q(cell_q),
    .rd_oe(pv_oe), .rd_val(pv_rd), .err(err_o)
  );
endmodule

// File: rtl/nvs_word_store_chk.sv
module nvs_word_store_chk #(
  parameter int unsigned W = 11
) (
  input logic         clk,
  input logic         rst,
  input logic         pv_oe,
  input logic         pv_rd,
  input logic [W-1:0] cell_q,
  input logic         err_o
);
  // R1
  rst_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cell_q == {W{1'b1}} && !pv_oe && !err_o));

  // R10
  rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !pv_oe |-> !pv_rd);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (cell_q == $past(cell_q)));

  // R3
  one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (cell_q != $past(cell_q)) |->
      (cell_q == {W{1'b1}}) ||
      ($countones(cell_q ^ $past(cell_q)) == 1 && (cell_q & ~$past(cell_q)) == '0));

  // R11
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);
endmodule

bind nvs_word_store nvs_word_store_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .pv_oe(pv_oe), .pv_rd(pv_rd),
  .cell_q(cell_q), .err_o(err_o)
);

// File: tb/nvs_word_store_test.sv
module nvs_word_store_test;
  localparam int W  = 11;
  localparam int MP = 40;
  localparam int MI = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic da = 1'b1, sclk = 1'b0, pv = 1'b0;
  logic pv_oe, pv_rd, err_o;
  logic [W-1:0] cell_q;

  always #2.5 clk = ~clk;

  nvs_word_store #(.W(W), .MIN_PULSE(MP), .MIN_IDLE(MI), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .da_in(da), .sclk_in(sclk), .pv_in(pv),
    .pv_oe(pv_oe), .pv_rd(pv_rd), .cell_q(cell_q), .err_o(err_o)
  );

  typedef struct { int kind; int exp; string tag; } item_t;
  item_t sbq[$];
  int checks = 0, fails = 0, err_cnt = 0;
  bit done = 0;
  logic [W-1:0] model = '1;

  always @(negedge clk) if (!rst && err_o) err_cnt++;

  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      int act;
      it = sbq.pop_front();
      case (it.kind)
        0: act = int'(cell_q);
        1: act = int'(pv_oe);
        2: act = int'(pv_rd);
        default: act = err_cnt;
      endcase
      checks++;
      if (act != it.exp) begin
        fails++;
        $display("FAIL %s (kind %0d): actual %0h expected %0h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(int kind, int exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(logic [W-1:0] w, int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; da = w[i];
      wait_n(4);
      sclk = 1'b1;
      wait_n(4);
    end
    wait_n(6);
  endtask

  task automatic strobe(int hi, int lo);
    pv = 1'b1; wait_n(hi);
    pv = 1'b0; wait_n(lo);
  endtask

  task automatic program_word(logic [W-1:0] w, int err_delta, string tag);
    int base;
    base = err_cnt;
    shift_bits(w, W);
    strobe(MP + 20, MI + 20);
    push(0, int'(model), tag);
    push(3, base + err_delta, tag);
  endtask

  task automatic read_bit(int k, int exp_v, string tag);
    shift_bits(~(W'(1) << k), W);
    da = 1'b1;
    wait_n(8);
    push(1, 1, tag);
    push(2, exp_v, tag);
  endtask

  initial begin
    int base;
    wait_n(6);
    rst = 1'b0;
    wait_n(2);
    // R1 shipped state
    push(0, 'h7FF, "R1 cells after reset");
    push(1, 0, "R1 no drive after reset");
    push(3, 0, "R1 no error after reset");

    // R9 / R2 fresh read of bit 5
    read_bit(5, 1, "R9 read set bit5");
    da = 1'b0; wait_n(8);
    push(1, 0, "R10 data low closes window");
    push(2, 0, "R10 value quiet");

    // R3 program bit2 then bit4
    model[2] = 1'b0;
    program_word(~(W'(1) << 2), 0, "R3 program bit2 / R11");
    da = 1'b1; wait_n(8);
    push(1, 0, "R12 no read after commit");
    model[4] = 1'b0;
    program_word(~(W'(1) << 4), 0, "R3 program bit4");
    read_bit(2, 0, "R9 read cleared bit2");
    read_bit(4, 0, "R9 read cleared bit4");
    read_bit(3, 1, "R9 read set bit3");

    // R10 multi-zero read
    shift_bits(~W'(3), W); da = 1'b1; wait_n(8);
    push(1, 0, "R10 multi-zero word not driven");

    // R4 short pulse
    base = err_cnt;
    shift_bits(~(W'(1) << 7), W);
    strobe(MP / 2, MI + 20);
    push(0, int'(model), "R4 short pulse no change");
    push(3, base + 1, "R4 short pulse error");

    // R5 early re-rise: abort, then a short pulse
    base = err_cnt;
    shift_bits(~(W'(1) << 7), W);
    strobe(MP + 20, 2);
    strobe(3, MI + 20);
    push(0, int'(model), "R5 abort no change");
    push(3, base + 2, "R5 abort error");

    // R7 two zeros
    program_word(~W'('h81), 1, "R7 multi-zero rejected");

    // R8 partial word
    base = err_cnt;
    shift_bits(~(W'(1) << 1), 5);
    strobe(MP + 20, MI + 20);
    push(0, int'(model), "R8 partial word no change");
    push(3, base + 1, "R8 partial word error");

    // R2 order: bit9 (reverse order would hit bit1)
    model[9] = 1'b0;
    program_word(~(W'(1) << 9), 0, "R2 program bit9");
    base = err_cnt;
    strobe(MP + 20, MI + 20);
    push(0, int'(model), "R12 strobe without reshift no change");
    push(3, base + 1, "R12 strobe without reshift error");

    // R6 erase
    model = '1;
    program_word('1, 0, "R6 erase");
    read_bit(0, 1, "R6 check bit high");
    read_bit(9, 1, "R6 bit9 restored");
    model[0] = 1'b0;
    program_word(~W'(1), 0, "R3 program bit0");
    read_bit(0, 0, "R9 read bit0 cleared");
    model = '1;
    program_word('1, 0, "R6 erase restores bit0");

    wait_n(4);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule